// File: doc/BRIEF.md
# Register Lifetime Criticality Monitor

This block observes the life of every physical register in a renamed register file and, per entry, totals the cycles during which a corrupted bit could have reached the program's output. A register version begins at allocation, receives one write, is read zero or more times and ends at deallocation. Only the stretch from the write to the last read is exposure. The time before the write and the time after the final read hold no value that anything will use.

Nothing knows which read is the last one when it happens. The monitor therefore keeps two timestamps per entry: the write cycle and the most recent read cycle. It closes the interval when the version is deallocated, because at that point the newest read is known to have been the last. The credit is added to the entry's saturating counter and to a saturating total. A registered read-out port returns any one entry's counter. A clear input zeroes all counters. Reads that arrive for a register that is not live or not yet written are dropped and set a sticky error flag.

Top module: `crit_life_monitor`

## Requirements
- R1: After reset, every entry counter, the total, the query output and the protocol-error flag are zero, and the cycle timestamp starts at zero.
- R2: When a version is deallocated after being written and read, its entry counter grows by the number of cycles from its write cycle to its latest read cycle (read cycle number minus write cycle number).
- R3: The cycles from allocation to the write and from the latest read to deallocation add nothing, and a version that was written but never read adds zero.
- R4: Re-allocating an entry starts a fresh version. Each version's credit is added on top of the entry's earlier credits.
- R5: Events on the same entry in one cycle take effect in the order allocate, write, read, deallocate. A read in the same cycle as the write is valid and gives a credit of zero. A read in the same cycle as the deallocation still counts.
- R6: Up to four read events per cycle are accepted on independent ports. Any port, or several ports at once, may name the same entry.
- R7: A read of an entry that is not allocated, or that is allocated but not yet written, changes no counter and sets a protocol-error flag that stays set until reset.
- R8: The query output shows, one cycle after the index is presented, the counter of the entry named by that index as it stood before that clock edge. An index of 80 or more gives zero.
- R9: The total output is the saturating sum of all credits added since reset or the last clear.
- R10: A clear zeroes all entry counters and the total, and any credit arriving in the same cycle is dropped. Versions in flight keep their timestamps and are credited normally when they later end.
- R11: Entry counters and the total saturate at their all-ones value and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Zero all counters and the total |
| alloc_vld | input | 1 | Allocate event valid |
| alloc_idx | input | IDX_W | Entry being allocated |
| wr_vld | input | 1 | Write event valid |
| wr_idx | input | IDX_W | Entry being written |
| rd_vld | input | NUM_RD | Per-port read event valid |
| rd_idx | input | NUM_RD*IDX_W | Per-port read entry index, port p in bits p*IDX_W upward |
| dealloc_vld | input | 1 | Deallocate event valid |
| dealloc_idx | input | IDX_W | Entry being released |
| query_idx | input | IDX_W | Entry whose counter is requested |
| query_cnt | output | CNT_W | Requested counter, one cycle later |
| total_cnt | output | CNT_W | Saturating sum of all credits |
| proto_err | output | 1 | Sticky flag for ignored reads |

## Verification
The bench aims at single cycles where several events hit the same entry. If the design applied a deallocation before a read, the credit would shrink. If it ran a read before the write, an error would be flagged falsely. It also checks versions with gaps before the write and after the last read: a design that closed the interval at deallocation, or opened it at allocation, would over-count there. Other cases are a clear while a version is live, which must not lose that version's later credit, and long random runs that drive counters into saturation, where a wrapping adder would show a small value. The bench also queries indexes past the last entry and reads entries that are dead or not yet written; both must leave every counter as it was.

// File: rtl/clm_pkg.sv
// Shared types and helpers for the register lifetime criticality monitor.
// Assumes counter and timestamp widths of at most 63 bits.
package clm_pkg;

    // Per-entry version state.
    typedef struct packed {
        logic live;      // version allocated and not yet released
        logic written;   // version has received its write
        logic seen_rd;   // at least one valid read since the write
    } ver_flags_t;

    // Saturating add: returns min(a + b, maxv). Inputs must be below 2**63.
    function automatic logic [63:0] sat_add(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] maxv);
        logic [63:0] s;
        s = a + b;
        return (s > maxv) ? maxv : s;
    endfunction

endpackage

// File: rtl/clm_entry.sv
// One register-file entry of the criticality monitor.
// Tracks the live version's write and latest-read timestamps, applies the
// cycle's events in the order allocate, write, read, deallocate, and on
// release credits (latest read - write) to a saturating counter.
// Assumes the parent decodes the event indexes into per-entry hit strobes.
module clm_entry #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TS_W-1:0]  stamp,
    input  logic             alloc_hit,
    input  logic             wr_hit,
    input  logic             rd_hit,
    input  logic             dealloc_hit,
    output logic [CNT_W-1:0] cnt,
    output logic [TS_W-1:0]  delta,
    output logic             rd_bad
);
    import clm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    ver_flags_t       flags, flags_n;
    logic [TS_W-1:0]  wr_ts, wr_ts_n;
    logic [TS_W-1:0]  rd_ts, rd_ts_n;
    logic [CNT_W-1:0] cnt_n;

    // Apply this cycle's events in their fixed order and form the credit.
    always_comb begin
        flags_n = flags;
        wr_ts_n = wr_ts;
        rd_ts_n = rd_ts;
        delta   = '0;
        rd_bad  = 1'b0;
        if (alloc_hit) begin
            flags_n = '{live: 1'b1, written: 1'b0, seen_rd: 1'b0};
        end
        if (wr_hit && flags_n.live) begin
            flags_n.written = 1'b1;
            flags_n.seen_rd = 1'b0;
            wr_ts_n         = stamp;
        end
        if (rd_hit) begin
            if (flags_n.live && flags_n.written) begin
                flags_n.seen_rd = 1'b1;
                rd_ts_n         = stamp;
            end else begin
                rd_bad = 1'b1;
            end
        end
        if (dealloc_hit && flags_n.live) begin
            if (flags_n.written && flags_n.seen_rd) begin
                delta = rd_ts_n - wr_ts_n;
            end
            flags_n = '0;
        end
    end

    // Next counter value: cleared, or saturating sum with the credit.
    always_comb begin
        if (clear) begin
            cnt_n = '0;
        end else begin
            cnt_n = CNT_W'(sat_add(64'(cnt), 64'(delta), 64'(CNT_MAX)));
        end
    end

    // Register version state, timestamps and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            wr_ts <= '0;
            rd_ts <= '0;
            cnt   <= '0;
        end else begin
            flags <= flags_n;
            wr_ts <= wr_ts_n;
            rd_ts <= rd_ts_n;
            cnt   <= cnt_n;
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> cnt >= $past(cnt)); // R11

    AST_VER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_hit |=> !flags.live); // R4

endmodule

// File: rtl/clm_readout.sv
// Read-out side of the monitor: registered per-entry query with a one-cycle
// latency and the saturating running total of all credits.
// Assumes at most one entry produces a nonzero credit per cycle.
module clm_readout #(
    parameter int NUM_ENTRIES = 80,
    parameter int TS_W        = 32,
    parameter int CNT_W       = 32,
    parameter int IDX_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] cnts [NUM_ENTRIES],
    input  logic [TS_W-1:0]  delta_any,
    input  logic [IDX_W-1:0] query_idx,
    output logic [CNT_W-1:0] query_cnt,
    output logic [CNT_W-1:0] total_cnt
);
    import clm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] sel_cnt;

    // Select the queried counter; out-of-range indexes read as zero.
    always_comb begin
        sel_cnt = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (int'(query_idx) == e) sel_cnt = cnts[e];
        end
    end

    // Register the query result and accumulate the total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            query_cnt <= '0;
            total_cnt <= '0;
        end else begin
            query_cnt <= sel_cnt;
            if (clear) begin
                total_cnt <= '0;
            end else begin
                total_cnt <= CNT_W'(sat_add(64'(total_cnt), 64'(delta_any),
                                            64'(CNT_MAX)));
            end
        end
    end

    AST_TOTAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> total_cnt >= $past(total_cnt)); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> total_cnt == '0); // R10

    AST_QUERY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(query_idx) >= NUM_ENTRIES |=> query_cnt == '0); // R8

endmodule

// File: rtl/crit_life_monitor.sv
// Register lifetime criticality monitor (top).
// Keeps the cycle timestamp, decodes the allocate, write, read and
// deallocate events into per-entry strobes, instantiates one tracker per
// entry, merges credits and bad-read flags, and hosts the read-out.
// Assumes at most one allocate, one write, one deallocate and NUM_RD reads
// per cycle; event indexes at or above NUM_ENTRIES match no entry.
module crit_life_monitor #(
    parameter int NUM_ENTRIES = 80,
    parameter int NUM_RD      = 4,
    parameter int TS_W        = 32,
    parameter int CNT_W       = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    alloc_vld,
    input  logic [IDX_W-1:0]        alloc_idx,
    input  logic                    wr_vld,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [NUM_RD-1:0]       rd_vld,
    input  logic [NUM_RD*IDX_W-1:0] rd_idx,
    input  logic                    dealloc_vld,
    input  logic [IDX_W-1:0]        dealloc_idx,
    input  logic [IDX_W-1:0]        query_idx,
    output logic [CNT_W-1:0]        query_cnt,
    output logic [CNT_W-1:0]        total_cnt,
    output logic                    proto_err
);

    logic [TS_W-1:0]        stamp;
    logic [CNT_W-1:0]       cnts    [NUM_ENTRIES];
    logic [TS_W-1:0]        deltas  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] bad_vec;
    logic [NUM_ENTRIES-1:0] credit_vec;
    logic [TS_W-1:0]        delta_any;

    // Free-running cycle timestamp used for write and read marks.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + 1'b1;
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic a_hit, w_hit, r_hit, d_hit;

        // Decode the event buses into this entry's strobes.
        always_comb begin
            a_hit = alloc_vld   && (alloc_idx   == IDX_W'(i));
            w_hit = wr_vld      && (wr_idx      == IDX_W'(i));
            d_hit = dealloc_vld && (dealloc_idx == IDX_W'(i));
            r_hit = 1'b0;
            for (int p = 0; p < NUM_RD; p++) begin
                if (rd_vld[p] && (rd_idx[p*IDX_W +: IDX_W] == IDX_W'(i)))
                    r_hit = 1'b1;
            end
        end

        clm_entry #(
            .TS_W (TS_W),
            .CNT_W(CNT_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear),
            .stamp      (stamp),
            .alloc_hit  (a_hit),
            .wr_hit     (w_hit),
            .rd_hit     (r_hit),
            .dealloc_hit(d_hit),
            .cnt        (cnts[i]),
            .delta      (deltas[i]),
            .rd_bad     (bad_vec[i])
        );

        assign credit_vec[i] = |deltas[i];
    end

    // Merge credits; only the released entry can be nonzero.
    always_comb begin
        delta_any = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) delta_any = delta_any | deltas[e];
    end

    // Sticky flag for reads of dead or unwritten entries.
    always_ff @(posedge clk) begin
        if (!rst_n)        proto_err <= 1'b0;
        else if (|bad_vec) proto_err <= 1'b1;
    end

    clm_readout #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .TS_W       (TS_W),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .cnts     (cnts),
        .delta_any(delta_any),
        .query_idx(query_idx),
        .query_cnt(query_cnt),
        .total_cnt(total_cnt)
    );

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R7

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stamp == $past(stamp) + 1'b1); // R2

    AST_ONE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(credit_vec)); // R9

    AST_CREDIT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_vec != '0) |-> dealloc_vld); // R3

endmodule

// File: tb/sim_crit_life_monitor.sv
module sim_crit_life_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 80;
    localparam int NRD   = 4;
    localparam int IW    = 7;
    localparam int CW    = 10;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clear;
    logic          a_v, w_v, d_v;
    logic [IW-1:0] a_i, w_i, d_i, q_i;
    logic [NRD-1:0]    r_v;
    logic [NRD*IW-1:0] r_i;
    logic [CW-1:0] q_cnt, tot;
    logic          err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit          mv [N];
    bit          mw [N];
    bit          mr [N];
    logic [31:0] mwts [N];
    logic [31:0] mrts [N];
    int          mcnt [N];
    int          mtot;
    bit          merr;
    logic [31:0] tb_now;
    bit          sat_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    crit_life_monitor #(
        .NUM_ENTRIES(N),
        .NUM_RD     (NRD),
        .TS_W       (32),
        .CNT_W      (CW),
        .IDX_W      (IW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .alloc_vld(a_v), .alloc_idx(a_i),
        .wr_vld(w_v), .wr_idx(w_i),
        .rd_vld(r_v), .rd_idx(r_i),
        .dealloc_vld(d_v), .dealloc_idx(d_i),
        .query_idx(q_i), .query_cnt(q_cnt),
        .total_cnt(tot), .proto_err(err)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(int a, longint d);
        longint s;
        s = longint'(a) + d;
        return (s > CMAX) ? CMAX : int'(s);
    endfunction

    task automatic quiet();
        clear = 0; a_v = 0; w_v = 0; d_v = 0; r_v = '0;
    endtask

    // Expected behaviour computed from the requirements.
    task automatic model_apply();
        longint credit;
        int k;
        credit = 0;
        if (a_v) begin
            k = int'(a_i); mv[k] = 1; mw[k] = 0; mr[k] = 0;
        end
        if (w_v && mv[int'(w_i)]) begin
            k = int'(w_i); mw[k] = 1; mr[k] = 0; mwts[k] = tb_now;
        end
        for (int p = 0; p < NRD; p++) begin
            if (r_v[p]) begin
                k = int'(r_i[p*IW +: IW]);
                if (mv[k] && mw[k]) begin
                    mr[k] = 1; mrts[k] = tb_now;
                end else begin
                    merr = 1;
                end
            end
        end
        if (d_v && mv[int'(d_i)]) begin
            k = int'(d_i);
            if (mw[k] && mr[k]) credit = longint'(mrts[k] - mwts[k]);
            mv[k] = 0; mw[k] = 0; mr[k] = 0;
            if (!clear) mcnt[k] = sat(mcnt[k], credit);
        end
        if (clear) begin
            for (int e = 0; e < N; e++) mcnt[e] = 0;
            mtot = 0;
        end else begin
            mtot = sat(mtot, credit);
        end
        if (mtot == CMAX) sat_seen = 1;
    endtask

    // One clock: model, edge, then compare the outputs (R8, R9, R7).
    task automatic tick();
        int exp_q;
        exp_q = (int'(q_i) < N) ? mcnt[int'(q_i)] : 0;
        model_apply();
        @(posedge clk);
        tb_now = tb_now + 1;
        @(negedge clk);
        chk("R8 query", q_cnt, exp_q);
        chk("R9 total", tot, mtot);
        chk("R7 error flag", err, merr);
        quiet();
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) tick();
    endtask

    task automatic query(int idx, string req, int exp);
        q_i = IW'(idx);
        tick();
        chk(req, q_cnt, exp);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < N; e++) begin
            mv[e] = 0; mw[e] = 0; mr[e] = 0; mwts[e] = 0; mrts[e] = 0; mcnt[e] = 0;
        end
        mtot = 0; merr = 0; tb_now = 0; sat_seen = 0;
        quiet(); a_i = 0; w_i = 0; d_i = 0; q_i = 0; r_i = '0;
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state.
        chk("R1 query after reset", q_cnt, 0);
        chk("R1 total after reset", tot, 0);
        chk("R1 error after reset", err, 0);

        // R2: write then two reads, credit = last read - write = 7.
        a_v = 1; a_i = 5; tick();
        idle(1);
        w_v = 1; w_i = 5; tick();
        idle(2);
        r_v = 4'b0001; r_i[0 +: IW] = 5; tick();
        idle(3);
        r_v = 4'b0010; r_i[IW +: IW] = 5; tick();
        idle(1);
        d_v = 1; d_i = 5; tick();
        query(5, "R2 write-to-last-read credit", 7);

        // R3: gaps before write and after last read excluded; credit 2.
        a_v = 1; a_i = 6; tick();
        idle(2);
        w_v = 1; w_i = 6; tick();
        idle(1);
        r_v = 4'b0100; r_i[2*IW +: IW] = 6; tick();
        idle(3);
        d_v = 1; d_i = 6; tick();
        query(6, "R3 non-critical gaps excluded", 2);
        // R3: a never-read version adds zero.
        a_v = 1; a_i = 6; tick();
        w_v = 1; w_i = 6; tick();
        idle(2);
        d_v = 1; d_i = 6; tick();
        query(6, "R3 unread version adds zero", 2);

        // R4: second version of entry 5 adds 4 to the earlier 7.
        a_v = 1; a_i = 5; tick();
        w_v = 1; w_i = 5; tick();
        idle(3);
        r_v = 4'b1000; r_i[3*IW +: IW] = 5; tick();
        d_v = 1; d_i = 5; tick();
        query(5, "R4 per-version accumulation", 11);

        // R5: allocate, write, read, deallocate all in one cycle.
        a_v = 1; a_i = 7; w_v = 1; w_i = 7; d_v = 1; d_i = 7;
        r_v = 4'b0100; r_i[2*IW +: IW] = 7; tick();
        chk("R5 same-cycle order no error", err, 0);
        query(7, "R5 same-cycle credit zero", 0);

        // R5/R6: read with write, then four ports read with deallocation.
        a_v = 1; a_i = 9; tick();
        w_v = 1; w_i = 9; r_v = 4'b0001; r_i[0 +: IW] = 9; tick();
        idle(4);
        r_v = 4'b1111;
        for (int p = 0; p < NRD; p++) r_i[p*IW +: IW] = 9;
        d_v = 1; d_i = 9; tick();
        chk("R6 four-port read no error", err, 0);
        query(9, "R6 read before release counts", 5);

        // R7: read of an unallocated entry is ignored and flagged.
        r_v = 4'b0001; r_i[0 +: IW] = 70; tick();
        chk("R7 flag set", err, 1);
        idle(3);
        chk("R7 flag sticky", err, 1);
        query(70, "R7 ignored read leaves counter", 0);

        // R8: out-of-range index returns zero.
        query(100, "R8 out-of-range query", 0);

        // R10: clear during a live version; later credit still lands.
        a_v = 1; a_i = 11; tick();
        w_v = 1; w_i = 11; tick();
        clear = 1; tick();
        chk("R10 total cleared", tot, 0);
        idle(2);
        r_v = 4'b0001; r_i[0 +: IW] = 11; tick();
        d_v = 1; d_i = 11; tick();
        query(11, "R10 in-flight version after clear", 4);
        query(5, "R10 old counter cleared", 0);
        chk("R10 total after clear", tot, 4);

        // Random traffic on a small index window to force collisions.
        for (int c = 0; c < 30000; c++) begin
            a_v = ($urandom % 4) == 0;  a_i = IW'($urandom % 16);
            w_v = ($urandom % 2) == 0;  w_i = IW'($urandom % 16);
            for (int p = 0; p < NRD; p++) begin
                r_v[p] = ($urandom % 3) == 0;
                r_i[p*IW +: IW] = IW'($urandom % 16);
            end
            d_v = ($urandom % 8) == 0;  d_i = IW'($urandom % 16);
            clear = ($urandom % 6000) == 0;
            q_i = IW'($urandom % 84);
            tick();
        end
        chk("R11 total reached saturation", sat_seen, 1);
        chk("R11 total held at max", tot, mtot);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule